// File: doc/BRIEF.md
# High-Voltage Startup Interlock Sequencer

This block walks a tube-driven high-voltage installation through a safe power-up. A heater warm-up runs first. The operator then commands the grid supply on. Once the grid bias holds steady, a settle delay runs, and a timed screen reset pulse follows it. Only after that pulse ends are the screen and the main high-voltage supply released.

Each delay is a counter that advances on a one-per-second tick from an internal prescaler. The tick period and every delay length are parameters, so a bench can shrink them. Losing the bias sends the sequence back to wait for the bias again, and every timer starts over. A screen trip locks the system out until the operator switches the grid supply off.

The interlock inputs are door, filament and cooling. They gate the enables directly, so a fault removes high voltage in the same clock cycle, before the state register reacts.

Top module: `hv_interlock_seq`

## Requirements
- R1: `hv_en_o` is high only when the step is RUN (5) and door, filament, cooling and bias are all true and `screen_trip_i` is low. It falls in the same cycle that any of these conditions fails.
- R2: After reset the step is WARM (0) and all enables are low. The warm-up timer counts ticks only while the filament is on, and the sequence moves to READY (1) after WARM_TICKS ticks. Filament loss in any step returns the sequence to WARM and removes every enable.
- R3: In READY, a `grid_on_cmd_i` while door and cooling are true and no trip is latched moves the sequence to GRID (2), and `grid_ps_en_o` goes high. Otherwise the command is ignored.
- R4: In GRID, stable bias starts SETTLE (3), which lasts SETTLE_TICKS ticks. After it comes SRST (4), with `screen_rst_o` high.
- R5: SRST lasts RESET_TICKS ticks and is then followed by RUN (5), with `screen_en_o` high. `screen_rst_o` and `screen_en_o` are never high together, and RUN is entered only from SRST.
- R6: Bias loss in SETTLE, SRST or RUN returns the sequence to GRID (2) and clears both delay timers, so a full settle delay is needed again.
- R7: `screen_trip_i` in GRID, SETTLE, SRST or RUN moves the sequence to TRIPPED (6) and sets `trip_latched_o`. In TRIPPED all enables are low.
- R8: `trip_latched_o` stays set until `grid_off_cmd_i`, and `grid_on_cmd_i` is refused while it is set. `grid_off_cmd_i` in any step from READY onward goes to READY and clears the latch.
- R9: Loss of door or cooling in GRID through RUN returns the sequence to READY (1). The grid supply drops in that same cycle.
- R10: The conditions are taken in this priority order: filament loss, grid-off command, screen trip, door or cooling loss, bias loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| door_closed_i | input | 1 | all cabinet doors closed |
| filament_on_i | input | 1 | tube filament powered |
| cooling_ok_i | input | 1 | cooling system working |
| bias_stable_i | input | 1 | control-grid bias stable |
| screen_trip_i | input | 1 | screen supply trip |
| grid_on_cmd_i | input | 1 | operator grid-supply-on command |
| grid_off_cmd_i | input | 1 | operator grid-supply-off command |
| grid_ps_en_o | output | 1 | grid power-supply enable |
| screen_rst_o | output | 1 | screen trip reset pulse |
| screen_en_o | output | 1 | screen supply enable |
| hv_en_o | output | 1 | main high-voltage enable |
| step_o | output | 3 | present sequence step (0 WARM .. 6 TRIPPED) |
| trip_latched_o | output | 1 | screen trip lockout flag |

## Verification
On every cycle, the assertions check four things. High voltage is never present without all interlocks. The reset pulse and the screen enable are never high together. RUN is entered only from SRST, and a warm-up exit only follows a finished warm-up timer. They also check that the trip latch holds until the off command, and that bias loss in the upper steps falls back to GRID. The bench scenarios show the rest: the timer lengths in cycles, the full restart after bias loss, the refusal of grid-on while latched or with a door open, and the priority among faults that arrive together.

// File: rtl/hv_seq_pkg.sv
package hv_seq_pkg;
    typedef enum logic [2:0] {
        ST_WARM    = 3'd0,
        ST_READY   = 3'd1,
        ST_GRID    = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_SRST    = 3'd4,
        ST_RUN     = 3'd5,
        ST_TRIPPED = 3'd6
    } hv_step_e;

    typedef struct packed {
        hv_step_e step;
        logic     trip;
    } seq_state_t;

    localparam int NUM_TIMERS = 3;
    localparam int TMR_WARM   = 0;
    localparam int TMR_SETTLE = 1;
    localparam int TMR_RESET  = 2;
endpackage

// File: rtl/hv_tick_gen.sv
module hv_tick_gen #(
    parameter int CLKS_PER_TICK = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);

    assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/hv_delay_timer.sv
module hv_delay_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)                      cnt_d = '0;
        else if (tick_i && cnt_q < LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == LAST);

    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_timer_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/hv_interlock_seq.sv
module hv_interlock_seq #(
    parameter int CLKS_PER_TICK = 100_000_000,
    parameter int WARM_TICKS    = 600,
    parameter int SETTLE_TICKS  = 2,
    parameter int RESET_TICKS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       door_closed_i,
    input  logic       filament_on_i,
    input  logic       cooling_ok_i,
    input  logic       bias_stable_i,
    input  logic       screen_trip_i,
    input  logic       grid_on_cmd_i,
    input  logic       grid_off_cmd_i,
    output logic       grid_ps_en_o,
    output logic       screen_rst_o,
    output logic       screen_en_o,
    output logic       hv_en_o,
    output logic [2:0] step_o,
    output logic       trip_latched_o
);
    import hv_seq_pkg::*;

    localparam int LIMITS [NUM_TIMERS] = '{WARM_TICKS, SETTLE_TICKS, RESET_TICKS};

    seq_state_t st_d, st_q;
    logic tick;
    logic [NUM_TIMERS-1:0] tmr_run, tmr_done;
    logic guard_ok, grid_stage;

    hv_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    assign tmr_run[TMR_WARM]   = (st_q.step == ST_WARM) && filament_on_i;
    assign tmr_run[TMR_SETTLE] = (st_q.step == ST_SETTLE);
    assign tmr_run[TMR_RESET]  = (st_q.step == ST_SRST);

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        hv_delay_timer #(.LIMIT(LIMITS[g])) u_tmr (
            .clk(clk), .rst_n(rst_n), .run_i(tmr_run[g]),
            .tick_i(tick), .done_o(tmr_done[g])
        );
    end

    assign guard_ok   = door_closed_i && filament_on_i && cooling_ok_i;
    assign grid_stage = (st_q.step == ST_GRID) || (st_q.step == ST_SETTLE) ||
                        (st_q.step == ST_SRST) || (st_q.step == ST_RUN);

    always_comb begin
        st_d = st_q;
        if (!filament_on_i) begin
            st_d.step = ST_WARM;
        end else begin
            case (st_q.step)
                ST_WARM: begin
                    if (tmr_done[TMR_WARM]) st_d.step = ST_READY;
                end
                ST_READY: begin
                    if (grid_off_cmd_i)
                        st_d.trip = 1'b0;
                    else if (grid_on_cmd_i && !st_q.trip && door_closed_i && cooling_ok_i)
                        st_d.step = ST_GRID;
                end
                ST_TRIPPED: begin
                    if (grid_off_cmd_i) begin
                        st_d.step = ST_READY;
                        st_d.trip = 1'b0;
                    end
                end
                default: begin
                    if (grid_off_cmd_i) begin
                        st_d.step = ST_READY;
                        st_d.trip = 1'b0;
                    end else if (screen_trip_i) begin
                        st_d.step = ST_TRIPPED;
                        st_d.trip = 1'b1;
                    end else if (!door_closed_i || !cooling_ok_i) begin
                        st_d.step = ST_READY;
                    end else if (st_q.step != ST_GRID && !bias_stable_i) begin
                        st_d.step = ST_GRID;
                    end else begin
                        case (st_q.step)
                            ST_GRID:   if (bias_stable_i)          st_d.step = ST_SETTLE;
                            ST_SETTLE: if (tmr_done[TMR_SETTLE])   st_d.step = ST_SRST;
                            ST_SRST:   if (tmr_done[TMR_RESET])    st_d.step = ST_RUN;
                            default:   st_d.step = st_q.step;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{step: ST_WARM, trip: 1'b0};
        else        st_q <= st_d;
    end

    assign grid_ps_en_o   = grid_stage && guard_ok;
    assign screen_rst_o   = (st_q.step == ST_SRST) && guard_ok && bias_stable_i;
    assign screen_en_o    = (st_q.step == ST_RUN) && guard_ok && bias_stable_i;
    assign hv_en_o        = screen_en_o && !screen_trip_i;
    assign step_o         = st_q.step;
    assign trip_latched_o = st_q.trip;

    assert_hv_guarded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en_o |-> (door_closed_i && filament_on_i && cooling_ok_i &&
                     bias_stable_i && !screen_trip_i && step_o == 3'd5));
    assert_warm_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == ST_WARM && st_d.step != ST_WARM) |-> tmr_done[TMR_WARM]);
    assert_rst_en_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({screen_rst_o, screen_en_o}));
    assert_run_from_srst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step != ST_RUN) ##1 (st_q.step == ST_RUN) |-> $past(st_q.step) == ST_SRST);
    assert_bias_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.step == ST_SETTLE || st_q.step == ST_SRST || st_q.step == ST_RUN) &&
         guard_ok && !grid_off_cmd_i && !screen_trip_i && !bias_stable_i)
        |=> st_q.step == ST_GRID);
    assert_trip_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_stage && filament_on_i && screen_trip_i && !grid_off_cmd_i) |=> trip_latched_o);
    assert_trip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_latched_o && !grid_off_cmd_i) |=> trip_latched_o);
    assert_no_grid_when_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == ST_READY && trip_latched_o) |=> st_q.step != ST_GRID);
endmodule

// File: tb/hv_interlock_seq_test.sv
module hv_interlock_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int WT = 5;
    localparam int ST = 3;
    localparam int RT = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic door = 1'b1, fil = 1'b1, cool = 1'b1, bias = 1'b0, strip = 1'b0;
    logic gon = 1'b0, goff = 1'b0;
    logic grid_en, srst, sen, hv, trip_l;
    logic [2:0] step;
    int total = 0, bad = 0, cycles = 0;
    bit done = 1'b0;

    hv_interlock_seq #(.CLKS_PER_TICK(P), .WARM_TICKS(WT), .SETTLE_TICKS(ST),
                       .RESET_TICKS(RT)) uut (
        .clk(clk), .rst_n(rst_n), .door_closed_i(door), .filament_on_i(fil),
        .cooling_ok_i(cool), .bias_stable_i(bias), .screen_trip_i(strip),
        .grid_on_cmd_i(gon), .grid_off_cmd_i(goff), .grid_ps_en_o(grid_en),
        .screen_rst_o(srst), .screen_en_o(sen), .hv_en_o(hv), .step_o(step),
        .trip_latched_o(trip_l)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nxt(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wait_step(int target, int maxc, output int n);
        n = 0;
        while (int'(step) != target && n < maxc) begin nxt(); n++; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; door = 1; fil = 1; cool = 1; bias = 0; strip = 0; gon = 0; goff = 0;
        nxt(2); rst_n = 1'b1; #1;
    endtask

    task automatic pulse_on();  gon = 1;  nxt(); gon = 0;  #1; endtask
    task automatic pulse_off(); goff = 1; nxt(); goff = 0; #1; endtask

    task automatic bring_up();
        int n;
        do_reset();
        wait_step(1, 100, n);
        pulse_on();
        bias = 1;
        wait_step(5, 100, n);
    endtask

    function automatic int exp_next_run(bit f, bit d, bit c, bit b, bit t, bit off);
        if (!f) return 0;
        if (off) return 1;
        if (t) return 6;
        if (!d || !c) return 1;
        if (!b) return 2;
        return 5;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(1234));
        #1;
        chk(step == 0 && !grid_en && !hv && !srst && !sen && !trip_l, "R2 reset state", step, 0);
        rst_n = 1'b1; #1;

        // R2: filament off holds WARM
        fil = 0;
        nxt(WT*P + 8);
        chk(step == 0, "R2 no warm-up without filament", step, 0);
        fil = 1; #1;
        wait_step(1, 100, n);
        chk(step == 1 && n >= (WT-1)*P && n <= WT*P + 2, "R2 warm-up length", n, WT*P);

        // R3: door open refuses grid-on
        door = 0; #1; pulse_on();
        chk(step == 1 && !grid_en, "R3 grid-on refused with door open", step, 1);
        door = 1; #1; pulse_on();
        chk(step == 2 && grid_en, "R3 grid-on accepted", step, 2);

        // R4 settle then reset pulse
        bias = 1; nxt();
        chk(step == 3, "R4 settle entered", step, 3);
        nxt(2);
        // R6: bias loss clears timers
        bias = 0; nxt();
        chk(step == 2, "R6 bias loss back to GRID", step, 2);
        bias = 1; nxt();
        wait_step(4, 100, n);
        chk(n >= (ST-1)*P && n <= ST*P + 2, "R6 full settle after restart", n, ST*P);
        #1 chk(srst && !sen, "R4 screen reset high", srst, 1);
        wait_step(5, 100, n);
        chk(n >= (RT-1)*P && n <= RT*P + 2, "R5 reset pulse length", n, RT*P);
        chk(sen && hv && !srst, "R5 run enables", hv, 1);

        // R1 same-cycle drop
        cool = 0; #1;
        chk(!hv && !grid_en, "R1 hv drops same cycle on cooling loss", hv, 0);
        nxt();
        chk(step == 1, "R9 cooling loss to READY", step, 1);
        cool = 1;

        // R9 door loss in SETTLE
        pulse_on(); nxt(); // GRID -> SETTLE
        chk(step == 3, "R9 setup settle", step, 3);
        door = 0; #1;
        chk(!grid_en, "R9 grid drop same cycle", grid_en, 0);
        nxt(); door = 1;
        chk(step == 1, "R9 door loss to READY", step, 1);

        // R7/R8 trip lockout
        pulse_on(); wait_step(5, 100, n);
        strip = 1; nxt(); strip = 0; #1;
        chk(step == 6 && trip_l && !grid_en && !hv, "R7 trip lockout", step, 6);
        pulse_on();
        chk(step == 6 && trip_l, "R8 grid-on ignored while tripped", step, 6);
        // filament loss keeps latch
        fil = 0; nxt(); fil = 1; #1;
        chk(step == 0 && trip_l, "R8 latch kept through warm-up", trip_l, 1);
        wait_step(1, 100, n);
        pulse_on();
        chk(step == 1 && trip_l, "R8 grid-on refused while latched", step, 1);
        pulse_off();
        chk(step == 1 && !trip_l, "R8 grid-off clears latch", trip_l, 0);
        pulse_on();
        chk(step == 2, "R8 grid-on after clear", step, 2);

        // R10 / R1 random faults in RUN
        for (int i = 0; i < 24; i++) begin
            bit f, d, c, b, t, o;
            int e;
            bring_up();
            chk(step == 5, "R5 bring-up reaches RUN", step, 5);
            f = ($urandom_range(3) != 0); d = ($urandom_range(3) != 0);
            c = ($urandom_range(3) != 0); b = ($urandom_range(3) != 0);
            t = ($urandom_range(3) == 0); o = ($urandom_range(7) == 0);
            fil = f; door = d; cool = c; bias = b; strip = t; goff = o; #1;
            chk(hv == (f && d && c && b && !t), "R1 hv gating random", hv, f && d && c && b && !t);
            nxt();
            e = exp_next_run(f, d, c, b, t, o);
            chk(int'(step) == e, "R10 fault priority", step, e);
            chk(trip_l == (f && !o && t), "R7 latch on random trip", trip_l, f && !o && t);
            goff = 0; strip = 0;
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule